// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial bus placed in front of a 128-byte memory. The bus clock and the open-drain data line are sampled with the system clock. The block finds start and stop conditions itself. It pulls the data line low only through an output-enable pin, and never drives it high.

After a start condition, the first byte gives the memory word address and the transfer direction. No separate device-select byte is used. In a write, each data byte goes straight to the memory array port. In a read, bytes are fetched from the array and shifted out for as long as the master keeps acknowledging.

When a write transfer closes with a stop, the block pulses a request to an external write-cycle engine. While that engine reports busy, the block stays silent. A master can therefore poll for completion by sending address bytes until one is acknowledged.

Top module: `tws_mem_slave`

## Requirements
- R1: Start is a high-to-low change of SDA while SCL is high; stop is a low-to-high change of SDA while SCL is high. Before the first start, the slave never pulls SDA low, whatever is clocked on the bus.
- R2: The first byte after a start is sent MSB first. Its bits 7..1 are the 7-bit word address and bit 0 is the direction (1 = read, 0 = write). The slave acknowledges this byte by holding SDA low through the ninth SCL clock.
- R3: In a write, every received data byte is acknowledged on the ninth clock. It is also presented once on the memory port (`memWe` high for one system clock) with the current word address.
- R4: After each written byte, only the low 2 address bits advance. They wrap within a 4-byte page and the upper 5 bits stay fixed, so a fifth byte overwrites the first location of the page.
- R5: In a read, the slave shifts out 8 bits MSB first and releases SDA during the ninth clock.
- R6: During a read, if the master pulls SDA low on the ninth clock, the next byte follows. If SDA is high on the ninth clock, the slave releases the bus and sends nothing more until a stop or a start.
- R7: The read address advances across all 7 bits after each byte, and wraps from 127 to 0.
- R8: While `wrBusy` is high, a start is ignored. The address byte gets no acknowledge and nothing is read or written.
- R9: A stop returns the slave to idle from any point of a transfer. A stop that ends a transfer in which at least one byte was written raises `wrStart` for exactly one clock.
- R10: A start in the middle of a transfer abandons the current operation. Reception restarts at the address byte, and a pending unwritten byte is dropped.
- R11: The SDA output enable changes only while SCL is low, after a detected SCL falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Bus clock as seen at the pad |
| sdaIn | input | 1 | Bus data as seen at the pad |
| sdaOe | output | 1 | When high, the pad pulls SDA low |
| memAddr | output | 7 | Memory word address |
| memWe | output | 1 | One-clock write strobe to the memory |
| memWrData | output | 8 | Byte to write |
| memRdData | input | 8 | Byte read at `memAddr`, one clock after the address |
| wrBusy | input | 1 | High while the write-cycle engine is busy |
| wrStart | output | 1 | One-clock request to start a write cycle |

## Verification
The bench builds the block with its default parameters: 4-byte pages (PAGE_W = 2) and a two-flop input synchronizer. This makes the page wrap reachable on the fifth byte of a page write. A sequential read that starts at address 126 reaches the 127-to-0 wrap.

The bench's write-cycle engine model holds busy for a short, fixed window. As a result, a polling loop sees several unanswered address bytes before the first acknowledge. Repeated starts, a stop in mid-byte and an extra byte clocked after a master NACK are each followed by fresh transfers, so stale state would show up on the bus.

// File: rtl/tws_pkg.sv
package tws_pkg;

  localparam int TWS_BYTE_W = 8;
  localparam int TWS_ADDR_W = TWS_BYTE_W - 1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX_ADDR,
    ST_ACK_ADDR,
    ST_RX_DATA,
    ST_ACK_DATA,
    ST_TX_DATA,
    ST_MACK,
    ST_HOLD
  } twsState_t;

  // Strobes from control to datapath, all single-cycle
  typedef struct packed {
    logic shiftIn;   // sample SDA into receive shifter
    logic cntInc;    // count one bus bit
    logic cntClr;    // restart the bit count
    logic loadWord;  // take the address from the received byte
    logic incSeq;    // full-width address increment (reads)
    logic incPage;   // low-bit address increment (writes)
    logic loadTx;    // load transmit shifter from memory
    logic shiftTx;   // advance transmit shifter
  } twsStrobe_t;

endpackage

// File: rtl/tws_bus_sync.sv
module tws_bus_sync #(
  parameter int SYNC_LEN = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  output logic sdaLvl,
  output logic sclRise,
  output logic sclFall,
  output logic startDet,
  output logic stopDet
);

  logic [SYNC_LEN-1:0] sclPipe;
  logic [SYNC_LEN-1:0] sdaPipe;
  logic sclPrev;
  logic sdaPrev;
  logic sclLvl;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPipe <= '1;
      sdaPipe <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPipe <= {sclPipe[SYNC_LEN-2:0], sclIn};
      sdaPipe <= {sdaPipe[SYNC_LEN-2:0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign sclLvl   = sclPipe[SYNC_LEN-1];
  assign sdaLvl   = sdaPipe[SYNC_LEN-1];
  assign sclRise  = sclLvl & ~sclPrev;
  assign sclFall  = ~sclLvl & sclPrev;
  assign startDet = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopDet  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;

endmodule

// File: rtl/tws_datapath.sv
module tws_datapath
  import tws_pkg::*;
#(
  parameter int PAGE_W = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sdaLvl,
  input  twsStrobe_t            strobe,
  input  logic [TWS_BYTE_W-1:0] memRdData,
  output logic [TWS_BYTE_W-1:0] rxByte,
  output logic                  txMsb,
  output logic                  cntFull,
  output logic [TWS_ADDR_W-1:0] wordAddr
);

  localparam int CNT_W = $clog2(TWS_BYTE_W + 1);

  logic [TWS_BYTE_W-1:0] rxReg;
  logic [TWS_BYTE_W-1:0] txReg;
  logic [CNT_W-1:0]      bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxReg    <= '0;
      txReg    <= '1;
      bitCnt   <= '0;
      wordAddr <= '0;
    end else begin
      if (strobe.shiftIn) rxReg <= {rxReg[TWS_BYTE_W-2:0], sdaLvl};

      if (strobe.cntClr)      bitCnt <= '0;
      else if (strobe.cntInc) bitCnt <= bitCnt + CNT_W'(1);

      if (strobe.loadWord)
        wordAddr <= rxReg[TWS_BYTE_W-1 -: TWS_ADDR_W];
      else if (strobe.incSeq)
        wordAddr <= wordAddr + TWS_ADDR_W'(1);
      else if (strobe.incPage)
        wordAddr <= {wordAddr[TWS_ADDR_W-1:PAGE_W], wordAddr[PAGE_W-1:0] + PAGE_W'(1)};

      if (strobe.loadTx)       txReg <= memRdData;
      else if (strobe.shiftTx) txReg <= {txReg[TWS_BYTE_W-2:0], 1'b1};
    end
  end

  assign rxByte  = rxReg;
  assign txMsb   = txReg[TWS_BYTE_W-1];
  assign cntFull = (bitCnt == CNT_W'(TWS_BYTE_W));

  // R7: read address wraps from the top of the array to zero
  p_seq_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incSeq && !strobe.loadWord && (&wordAddr)) |=> (wordAddr == '0));

  // R4: page increments never disturb the page number
  p_page_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.incPage && !strobe.loadWord && !strobe.incSeq) |=>
      (wordAddr[TWS_ADDR_W-1:PAGE_W] == $past(wordAddr[TWS_ADDR_W-1:PAGE_W])));

  // bit counter never runs past a full byte
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cntFull && !strobe.cntClr) |=> !$rose(bitCnt[0]));

endmodule

// File: rtl/tws_ctrl.sv
module tws_ctrl
  import tws_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclRise,
  input  logic       sclFall,
  input  logic       startDet,
  input  logic       stopDet,
  input  logic       sdaLvl,
  input  logic       wrBusy,
  input  logic       cntFull,
  input  logic       txMsb,
  input  logic       rxLsb,
  output twsStrobe_t strobe,
  output logic       sdaOe,
  output logic       memWe,
  output logic       wrStart
);

  twsState_t state, nextState;
  logic isRead;
  logic wrote;
  logic mackOk;

  always_comb begin
    strobe    = '0;
    memWe     = 1'b0;
    nextState = state;
    if (stopDet) begin
      nextState = ST_IDLE;
    end else if (startDet) begin
      strobe.cntClr = 1'b1;
      nextState     = wrBusy ? ST_IDLE : ST_RX_ADDR;
    end else begin
      unique case (state)
        ST_RX_ADDR, ST_RX_DATA: begin
          if (sclRise && !cntFull) begin
            strobe.shiftIn = 1'b1;
            strobe.cntInc  = 1'b1;
          end
          if (sclFall && cntFull) begin
            if (state == ST_RX_ADDR) begin
              strobe.loadWord = 1'b1;
              nextState       = ST_ACK_ADDR;
            end else begin
              memWe     = 1'b1;
              nextState = ST_ACK_DATA;
            end
          end
        end
        ST_ACK_ADDR: begin
          if (sclFall) begin
            strobe.cntClr = 1'b1;
            if (isRead) begin
              strobe.loadTx = 1'b1;
              nextState     = ST_TX_DATA;
            end else begin
              nextState = ST_RX_DATA;
            end
          end
        end
        ST_ACK_DATA: begin
          if (sclFall) begin
            strobe.cntClr  = 1'b1;
            strobe.incPage = 1'b1;
            nextState      = ST_RX_DATA;
          end
        end
        ST_TX_DATA: begin
          if (sclRise && !cntFull) strobe.cntInc = 1'b1;
          if (sclFall) begin
            if (cntFull) begin
              strobe.incSeq = 1'b1;
              strobe.cntClr = 1'b1;
              nextState     = ST_MACK;
            end else begin
              strobe.shiftTx = 1'b1;
            end
          end
        end
        ST_MACK: begin
          if (sclFall) begin
            if (mackOk) begin
              strobe.loadTx = 1'b1;
              nextState     = ST_TX_DATA;
            end else begin
              nextState = ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      isRead  <= 1'b0;
      wrote   <= 1'b0;
      mackOk  <= 1'b0;
      wrStart <= 1'b0;
    end else begin
      state   <= nextState;
      wrStart <= stopDet & wrote;
      if (stopDet)    wrote <= 1'b0;
      else if (memWe) wrote <= 1'b1;
      if (strobe.loadWord) isRead <= rxLsb;
      if (state == ST_MACK && sclRise) mackOk <= ~sdaLvl;
    end
  end

  assign sdaOe = (state == ST_ACK_ADDR) || (state == ST_ACK_DATA) ||
                 ((state == ST_TX_DATA) && !txMsb);

  // R11: the line is only ever pulled low after a falling bus clock
  p_drive_after_fall_r11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaOe) |-> $past(sclFall));

  // R11: release happens after a falling clock, or on a start/stop
  p_release_after_fall_r11: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaOe) |-> ($past(sclFall) || $past(startDet) || $past(stopDet)));

  // R8: a busy write cycle keeps the slave idle
  p_busy_silent_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrBusy && state == ST_IDLE) |=> (state == ST_IDLE && !sdaOe));

  // R9: stop always returns to idle
  p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> (state == ST_IDLE));

  // R9: write request is a single pulse
  p_wrstart_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    wrStart |=> !wrStart);

  // R3: no array write while the engine is busy
  p_we_not_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !wrBusy);

endmodule

// File: rtl/tws_mem_slave.sv
module tws_mem_slave
  import tws_pkg::*;
#(
  parameter int PAGE_W   = 2,
  parameter int SYNC_LEN = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaOe,
  output logic [TWS_ADDR_W-1:0] memAddr,
  output logic                  memWe,
  output logic [TWS_BYTE_W-1:0] memWrData,
  input  logic [TWS_BYTE_W-1:0] memRdData,
  input  logic                  wrBusy,
  output logic                  wrStart
);

  logic sdaLvl, sclRise, sclFall, startDet, stopDet;
  logic txMsb, cntFull;
  logic [TWS_BYTE_W-1:0] rxByte;
  twsStrobe_t strobe;

  tws_bus_sync #(.SYNC_LEN(SYNC_LEN)) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .sclIn    (sclIn),
    .sdaIn    (sdaIn),
    .sdaLvl   (sdaLvl),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet)
  );

  tws_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .sclRise  (sclRise),
    .sclFall  (sclFall),
    .startDet (startDet),
    .stopDet  (stopDet),
    .sdaLvl   (sdaLvl),
    .wrBusy   (wrBusy),
    .cntFull  (cntFull),
    .txMsb    (txMsb),
    .rxLsb    (rxByte[0]),
    .strobe   (strobe),
    .sdaOe    (sdaOe),
    .memWe    (memWe),
    .wrStart  (wrStart)
  );

  tws_datapath #(.PAGE_W(PAGE_W)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .sdaLvl    (sdaLvl),
    .strobe    (strobe),
    .memRdData (memRdData),
    .rxByte    (rxByte),
    .txMsb     (txMsb),
    .cntFull   (cntFull),
    .wordAddr  (memAddr)
  );

  assign memWrData = rxByte;

endmodule

// File: tb/tb_tws_mem_slave.sv
module tb_tws_mem_slave;

  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int BUSY_CYC   = 1500;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic sdaOe, memWe, wrStart, wrBusy;
  logic [6:0] memAddr;
  logic [7:0] memWrData, memRdData;
  logic sdaLine;

  int errors = 0;
  int checks = 0;
  int wrCount = 0;
  int oeViol = 0;
  int busyCnt = 0;
  logic [7:0] mem [128];
  logic [7:0] refMem [128];
  logic [14:0] expWr [$];
  logic sclPrevM = 1'b1;
  logic oePrev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sdaLine = sdaM & ~sdaOe;
  assign wrBusy  = (busyCnt != 0);

  tws_mem_slave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaOe(sdaOe),
    .memAddr(memAddr), .memWe(memWe), .memWrData(memWrData),
    .memRdData(memRdData), .wrBusy(wrBusy), .wrStart(wrStart)
  );

  // memory array model with one-clock read latency
  always @(posedge clk) begin
    if (memWe) mem[memAddr] <= memWrData;
    memRdData <= mem[memAddr];
  end

  // write-cycle engine model
  always @(posedge clk) begin
    if (!rstN) busyCnt <= 0;
    else if (wrStart) busyCnt <= BUSY_CYC;
    else if (busyCnt != 0) busyCnt <= busyCnt - 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor for memory writes (R3)
  always @(negedge clk) begin
    if (rstN && memWe) begin
      checks++;
      if (expWr.size() == 0) begin
        errors++;
        $display("FAIL R3 unexpected write actual=%0h expected=none", {memAddr, memWrData});
      end else begin
        logic [14:0] e;
        e = expWr.pop_front();
        if ({memAddr, memWrData} !== e) begin
          errors++;
          $display("FAIL R3 write actual=%0h expected=%0h", {memAddr, memWrData}, e);
        end
      end
    end
    if (rstN && wrStart) wrCount++;
    if (rstN && sclPrevM && sclM && (sdaOe !== oePrev)) oeViol++;
    sclPrevM = sclM;
    oePrev   = sdaOe;
  end

  task automatic waitQ();
    repeat (Q) @(posedge clk);
    #1;
  endtask

  task automatic busBit(input logic b, output logic seen);
    sdaM = b; waitQ();
    sclM = 1'b1; waitQ();
    @(negedge clk); seen = sdaLine;
    waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) busBit(b[i], s);
    busBit(1'b1, s);
    acked = ~s;
  endtask

  task automatic recvByte(input logic mAck, output logic [7:0] b);
    logic s;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      busBit(1'b1, s);
      b = {b[6:0], s};
    end
    busBit(~mAck, s);
  endtask

  task automatic busStart();
    sdaM = 1'b1; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b0; waitQ();
    sclM = 1'b0; waitQ();
  endtask

  task automatic busStop();
    sdaM = 1'b0; waitQ();
    sclM = 1'b1; waitQ();
    sdaM = 1'b1; waitQ(); waitQ();
  endtask

  task automatic pollReady(output int tries, output logic acked);
    tries = 0;
    acked = 1'b0;
    while (!acked && tries < 30) begin
      busStart();
      sendByte({7'h10, 1'b0}, acked);
      busStop();
      tries++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] b;
    int tries;
    for (int i = 0; i < 128; i++) begin
      mem[i]    = 8'((i * 7 + 3) & 255);
      refMem[i] = 8'((i * 7 + 3) & 255);
    end
    repeat (5) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R9 reset sdaOe", sdaOe, 0);
    chk("R9 reset wrStart", wrStart, 0);
    chk("R3 reset memWe", memWe, 0);

    // R1: bytes clocked with no start get no answer
    sclM = 1'b0; waitQ();
    sendByte({7'h10, 1'b0}, ack);
    chk("R1 no ack before start", ack, 0);
    sendByte(8'h00, ack);
    chk("R1 still silent", ack, 0);
    sdaM = 1'b1; waitQ(); sclM = 1'b1; waitQ();

    // R2, R3: byte write
    busStart();
    sendByte({7'h10, 1'b0}, ack);
    chk("R2 address ack", ack, 1);
    expWr.push_back({7'h10, 8'h5A}); refMem[7'h10] = 8'h5A;
    sendByte(8'h5A, ack);
    chk("R3 data ack", ack, 1);
    busStop();
    repeat (4) @(negedge clk);
    chk("R9 write request pulses", wrCount, 1);

    // R8: busy means silent, then polling succeeds
    busStart();
    sendByte({7'h10, 1'b0}, ack);
    chk("R8 no ack while busy", ack, 0);
    busStop();
    pollReady(tries, ack);
    chk("R8 poll eventually acked", ack, 1);
    chk("R8 poll needed retries", (tries > 1), 1);
    chk("R9 no request without data", wrCount, 1);

    // R4: page write with wrap inside page 0x20..0x23
    busStart();
    sendByte({7'h21, 1'b0}, ack);
    chk("R2 page address ack", ack, 1);
    begin
      logic [7:0] pd [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      logic [6:0] a = 7'h21;
      for (int i = 0; i < 5; i++) begin
        expWr.push_back({a, pd[i]});
        refMem[a] = pd[i];
        sendByte(pd[i], ack);
        chk("R4 page byte ack", ack, 1);
        a = {a[6:2], a[1:0] + 2'd1};
      end
    end
    busStop();
    repeat (4) @(negedge clk);
    chk("R9 page write request", wrCount, 2);
    pollReady(tries, ack);
    chk("R8 ready after page write", ack, 1);

    // R5: byte read
    busStart();
    sendByte({7'h10, 1'b1}, ack);
    chk("R2 read address ack", ack, 1);
    recvByte(1'b0, b);
    chk("R5 byte read", b, refMem[7'h10]);
    busStop();

    // R7, R6: sequential read across the top of the array
    busStart();
    sendByte({7'h7E, 1'b1}, ack);
    for (int i = 0; i < 4; i++) begin
      recvByte(i != 3, b);
      chk("R7 sequential byte", b, refMem[7'((126 + i) % 128)]);
    end
    recvByte(1'b0, b);
    chk("R6 silent after nack", b, 8'hFF);
    busStop();

    // R4: page contents after wrap
    busStart();
    sendByte({7'h20, 1'b1}, ack);
    for (int i = 0; i < 4; i++) begin
      recvByte(i != 3, b);
      chk("R4 page readback", b, refMem[7'(32 + i)]);
    end
    busStop();

    // R10: repeated start abandons a write and restarts addressing
    busStart();
    sendByte({7'h30, 1'b0}, ack);
    chk("R10 first address ack", ack, 1);
    busStart();
    sendByte({7'h10, 1'b1}, ack);
    chk("R10 restart address ack", ack, 1);
    recvByte(1'b0, b);
    chk("R10 read after restart", b, refMem[7'h10]);
    busStop();
    repeat (4) @(negedge clk);
    chk("R10 no write request", wrCount, 2);

    // R9: stop in the middle of a data byte
    busStart();
    sendByte({7'h40, 1'b0}, ack);
    busBit(1'b1, ack); busBit(1'b0, ack); busBit(1'b1, ack);
    busStop();
    repeat (4) @(negedge clk);
    chk("R9 idle after mid-byte stop", sdaOe, 0);
    chk("R9 no request after partial byte", wrCount, 2);
    busStart();
    sendByte({7'h10, 1'b1}, ack);
    chk("R9 fresh transfer acked", ack, 1);
    recvByte(1'b0, b);
    chk("R9 fresh transfer data", b, refMem[7'h10]);
    busStop();

    repeat (20) @(negedge clk);
    chk("R3 all expected writes seen", expWr.size(), 0);
    chk("R11 drive stable while SCL high", oeViol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule